// File: doc/BRIEF.md
# Eight-Channel 16-Bit Converter Serial Register Front End

This block is the digital side of an eight-channel, 16-bit voltage-output converter. A host sends 24-bit words over a four-wire serial port. An active-low frame signal marks each word, and each word carries an operation code, a channel address and a 16-bit value. Every channel holds its value in two stages. A staging (input) register takes new codes. A live (DAC) register drives the analog string. Codes move from staging to live in one of three ways: by an explicit command, by a load strobe pulsed low, or at once when the strobe is kept low.

A clear input acts on its falling edge. It forces both stages of every channel to zero scale or to midscale, as the reset-select pin chooses, and while it stays low the load strobe has no effect. Power-on reset sets the same value. The serial output can return one channel's live code during the frame that follows a readback request. It can also pass incoming bits on, so that several devices can be chained. Further outputs are a gain-of-two flag and a per-channel power-down mask.

All serial pins are taken to be in the `clk` domain. Each level of the serial clock is held for at least two `clk` cycles, and the host waits at least four cycles between frames.

Top module: `octdac_if`

## Requirements
- R1: While `rst` is high and after it is released, every live register reads 16'h8000 if `rst_sel` is 1 and 16'h0000 if it is 0. `pd_mask`, `gain_x2` and `sdo` are 0.
- R2: A frame is the span in which `sync_n` is low. Bits enter MSB first on falling `sclk` edges. Word bits [23:20] are the operation, [19:16] the channel address and [15:0] the data. The word takes effect after `sync_n` rises.
- R3: A frame with fewer than 24 falling `sclk` edges is dropped and changes no register.
- R4: Operation 1 writes the addressed staging register only. The live register keeps its value while `ldac_n` stays high.
- R5: Pulsing `ldac_n` low copies every staging register that holds unloaded data into its live register, all in the same cycle. Channels without unloaded data keep their values.
- R6: While `ldac_n` is held low, an operation-1 write reaches the live register within two `clk` cycles of the frame taking effect.
- R7: Operation 2 copies the addressed channel's staging register to its live register. Operation 3 writes the data to both registers.
- R8: A falling edge on `clr_n` loads the reset-select value into both registers of every channel and discards any unloaded data.
- R9: While `clr_n` is low, `ldac_n` has no effect on the live registers.
- R10: Operation 4 sets `pd_mask` to data[7:0], one bit per channel. Operation 5 sets `gain_x2` to data[0].
- R11: Operation 6 arms readback of the addressed channel. In the next frame, `sdo` presents {4'h0, address, live code} MSB first, changing on each rising `sclk` edge.
- R12: Operation 7 with data[0]=1 enables chaining. Frames may then exceed 24 bits, the last 24 bits take effect, and on each rising `sclk` edge `sdo` shows the bit shifted in 24 falling edges earlier.
- R13: A channel operation whose address is 8 or above changes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_sel | input | 1 | Reset value select: 1 = midscale, 0 = zero scale |
| sync_n | input | 1 | Active-low frame marker |
| sclk | input | 1 | Serial clock, oversampled by `clk` |
| sdi | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Clear input, acts on its falling edge |
| sdo | output | 1 | Serial data out, readback or chain |
| dac_flat | output | 128 | Live codes, channel n at [16n+15:16n] |
| pd_mask | output | 8 | Per-channel power-down flags |
| gain_x2 | output | 1 | Gain-of-two select |

## Verification
The bench builds the block at its default eight channels of 16 bits, so the frame is exactly 24 bits. At this width the 4-bit address field can name channels 8 to 15 that do not exist. Address 9 is used because its low three bits alias channel 1, which shows whether the decode truncates the address. The default width also places the top channel and a full 16-bit code inside the readback word, and a 48-bit chained frame can be checked against the bits that leave `sdo`.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    localparam int unsigned CMD_W  = 4;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [CMD_W-1:0] {
        OP_NOP     = 4'd0,
        OP_WR_IN   = 4'd1,
        OP_LOAD    = 4'd2,
        OP_WR_LOAD = 4'd3,
        OP_PWR     = 4'd4,
        OP_GAIN    = 4'd5,
        OP_RDBK    = 4'd6,
        OP_CHAIN   = 4'd7
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    // Code loaded on reset or clear: midscale sets only the top bit.
    function automatic logic [31:0] reset_code(input logic mid, input int unsigned w);
        reset_code = mid ? (32'd1 << (w - 1)) : 32'd0;
    endfunction

endpackage

// File: rtl/octdac_serial.sv
module octdac_serial #(
    parameter int unsigned FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_n,
    input  logic               sclk,
    input  logic               sdi,
    input  logic               chain_en,
    input  logic               rb_arm,
    input  logic [FRAME_W-1:0] rb_word,
    output logic               frame_start,
    output logic               frame_valid,
    output logic [FRAME_W-1:0] frame_word,
    output logic               sdo
);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

    logic               sync_q, sclk_q;
    logic               sync_rise, sclk_fall, sclk_rise;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] shreg, tx;

    assign frame_start = sync_q & ~sync_n;
    assign sync_rise   = ~sync_q & sync_n;
    assign sclk_fall   = sclk_q & ~sclk;
    assign sclk_rise   = ~sclk_q & sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            sync_q <= sync_n;
            sclk_q <= sclk;
        end
    end

    // Capture: shift on falling sclk, count up to a full word.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            shreg       <= '0;
            frame_valid <= 1'b0;
            frame_word  <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (frame_start) begin
                cnt <= '0;
            end else if (!sync_n && sclk_fall && (chain_en || cnt < CNT_W'(FRAME_W))) begin
                shreg <= {shreg[FRAME_W-2:0], sdi};
                if (cnt < CNT_W'(FRAME_W))
                    cnt <= cnt + 1'b1;
            end
            if (sync_rise) begin
                frame_valid <= (cnt == CNT_W'(FRAME_W));
                frame_word  <= shreg;
            end
        end
    end

    // Output: launch on rising sclk so the far side samples on falling.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx  <= '0;
            sdo <= 1'b0;
        end else if (frame_start) begin
            tx  <= rb_arm ? rb_word : '0;
            sdo <= 1'b0;
        end else if (!sync_n) begin
            if (sclk_rise)
                sdo <= chain_en ? shreg[FRAME_W-1] : tx[FRAME_W-1];
            if (sclk_fall)
                tx <= {tx[FRAME_W-2:0], 1'b0};
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_W));
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);
    p_short_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (sync_rise && cnt != CNT_W'(FRAME_W)) |=> !frame_valid);

endmodule

// File: rtl/octdac_chan.sv
module octdac_chan #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rst_val,
    input  logic              clear,
    input  logic              wr_in,
    input  logic              wr_dac,
    input  logic              ldac_go,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dac_q,
    output logic              pend
);
    logic [DATA_W-1:0] in_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            in_q  <= rst_val;
            dac_q <= rst_val;
            pend  <= 1'b0;
        end else if (wr_in && wr_dac) begin
            in_q  <= wr_data;
            dac_q <= wr_data;
            pend  <= 1'b0;
        end else if (wr_in) begin
            in_q  <= wr_data;
            pend  <= 1'b1;
        end else if (wr_dac || (ldac_go && pend)) begin
            dac_q <= in_q;
            pend  <= 1'b0;
        end
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (dac_q == $past(rst_val)) && !pend);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!clear && !wr_dac && !(ldac_go && pend)) |=> $stable(dac_q));

endmodule

// File: rtl/octdac_if.sv
module octdac_if
    import octdac_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rst_sel,
    input  logic                     sync_n,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic                     ldac_n,
    input  logic                     clr_n,
    output logic                     sdo,
    output logic [NUM_CH*DATA_W-1:0] dac_flat,
    output logic [NUM_CH-1:0]        pd_mask,
    output logic                     gain_x2
);
    localparam int unsigned FRAME_W = CMD_W + ADDR_W + DATA_W;
    localparam int unsigned HDR_W   = CMD_W + ADDR_W;

    logic               frame_start, frame_valid;
    logic [FRAME_W-1:0] frame_word, rb_word;
    hdr_t               hdr;
    logic [DATA_W-1:0]  data, rst_val, rb_data;
    logic               clr_q, clr_fall, ldac_go;
    logic               chain_en, rb_arm;
    logic [ADDR_W-1:0]  rb_addr;
    logic [DATA_W-1:0]  dac_q [NUM_CH];
    logic [NUM_CH-1:0]  pend;
    logic               op_in, op_dac;

    assign hdr     = frame_word[FRAME_W-1 -: HDR_W];
    assign data    = frame_word[DATA_W-1:0];
    assign rst_val = DATA_W'(reset_code(rst_sel, DATA_W));
    assign op_in   = (hdr.op == OP_WR_IN) || (hdr.op == OP_WR_LOAD);
    assign op_dac  = (hdr.op == OP_LOAD)  || (hdr.op == OP_WR_LOAD);

    always_ff @(posedge clk) begin
        if (rst) clr_q <= 1'b1;
        else     clr_q <= clr_n;
    end
    assign clr_fall = clr_q & ~clr_n;
    assign ldac_go  = ~ldac_n & clr_n;

    octdac_serial #(.FRAME_W(FRAME_W)) u_serial (
        .clk        (clk),
        .rst        (rst),
        .sync_n     (sync_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .chain_en   (chain_en),
        .rb_arm     (rb_arm),
        .rb_word    (rb_word),
        .frame_start(frame_start),
        .frame_valid(frame_valid),
        .frame_word (frame_word),
        .sdo        (sdo)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic sel;
        assign sel = frame_valid && (hdr.addr == ADDR_W'(ch));

        octdac_chan #(.DATA_W(DATA_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .rst_val(rst_val),
            .clear  (clr_fall),
            .wr_in  (sel && op_in),
            .wr_dac (sel && op_dac),
            .ldac_go(ldac_go),
            .wr_data(data),
            .dac_q  (dac_q[ch]),
            .pend   (pend[ch])
        );
        assign dac_flat[ch*DATA_W +: DATA_W] = dac_q[ch];
    end

    always_comb begin
        rb_data = '0;
        for (int ch = 0; ch < NUM_CH; ch++)
            if (rb_addr == ADDR_W'(ch)) rb_data = dac_q[ch];
    end
    assign rb_word = {CMD_W'(0), rb_addr, rb_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_mask  <= '0;
            gain_x2  <= 1'b0;
            chain_en <= 1'b0;
            rb_arm   <= 1'b0;
            rb_addr  <= '0;
        end else begin
            if (frame_start)
                rb_arm <= 1'b0;
            if (frame_valid) begin
                case (hdr.op)
                    OP_PWR:   pd_mask  <= data[NUM_CH-1:0];
                    OP_GAIN:  gain_x2  <= data[0];
                    OP_CHAIN: chain_en <= data[0];
                    OP_RDBK: begin
                        rb_arm  <= 1'b1;
                        rb_addr <= hdr.addr;
                    end
                    default: ;
                endcase
            end
        end
    end

    p_ldac_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !clr_fall && !frame_valid) |=> $stable(dac_flat));
    p_pend_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (ldac_go && !frame_valid && !clr_fall) |=> (pend == '0));

endmodule

// File: tb/octdac_if_tb_top.sv
module octdac_if_tb_top;
    localparam int NCH = 8;
    localparam int DW  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_sel = 1'b1;
    logic sync_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic ldac_n = 1'b1, clr_n = 1'b1;
    logic sdo;
    logic [NCH*DW-1:0] dac_flat;
    logic [NCH-1:0]    pd_mask;
    logic              gain_x2;

    always #5 clk = ~clk;

    octdac_if #(.NUM_CH(NCH), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .rst_sel(rst_sel), .sync_n(sync_n),
        .sclk(sclk), .sdi(sdi), .ldac_n(ldac_n), .clr_n(clr_n),
        .sdo(sdo), .dac_flat(dac_flat), .pd_mask(pd_mask), .gain_x2(gain_x2)
    );

    typedef struct {
        int          kind;   // 0 channel, 1 pd, 2 gain, 3 sdo capture, 4 sdo pin
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    logic [47:0] sdo_cap = '0;
    bit          done = 0;

    // Monitor: pops expected items and compares them away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = 32'(dac_flat[it.idx*DW +: DW]);
                    1:       act = 32'(pd_mask);
                    2:       act = 32'(gain_x2);
                    3:       act = 32'(sdo_cap[23:0]);
                    default: act = 32'(sdo);
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input int kind, input int idx, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic flush();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends the n low bits of b, MSB first; records sdo before each falling sclk.
    task automatic send_bits(input logic [47:0] b, input int n);
        @(negedge clk);
        sync_n = 1'b0;
        clks(2);
        for (int i = n - 1; i >= 0; i--) begin
            sdi  = b[i];
            sclk = 1'b1;
            clks(2);
            sdo_cap = {sdo_cap[46:0], sdo};
            sclk = 1'b0;
            clks(2);
        end
        sync_n = 1'b1;
        clks(5);
    endtask

    task automatic send_word(input logic [3:0] op, input logic [3:0] addr, input logic [15:0] d);
        send_bits({24'h0, op, addr, d}, 24);
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        clks(2);
        ldac_n = 1'b1;
        clks(3);
    endtask

    initial begin
        clks(5);
        // R1: values while reset is still asserted
        expect_item(0, 0, 32'h8000, "R1");
        expect_item(4, 0, 32'h0, "R1");
        flush();
        rst = 1'b0;
        clks(2);
        // R1: after reset release
        for (int c = 0; c < NCH; c++) expect_item(0, c, 32'h8000, "R1");
        expect_item(1, 0, 32'h0, "R1");
        expect_item(2, 0, 32'h0, "R1");
        flush();

        // R4: write input register only
        send_word(4'd1, 4'd2, 16'h1111);
        expect_item(0, 2, 32'h8000, "R4");
        flush();

        // R3: short frame of 23 bits is dropped
        send_bits({24'h0, 4'd3, 4'd5, 16'hAAAA} >> 1, 23);
        expect_item(0, 5, 32'h8000, "R3");
        flush();

        send_word(4'd1, 4'd6, 16'h6666);
        expect_item(0, 6, 32'h8000, "R4");
        flush();

        // R5: ldac pulse moves all pending channels together
        pulse_ldac();
        expect_item(0, 2, 32'h1111, "R5");
        expect_item(0, 6, 32'h6666, "R5");
        expect_item(0, 0, 32'h8000, "R5");
        flush();

        // R7 and R2: load command and write-and-load command
        send_word(4'd1, 4'd1, 16'h2222);
        expect_item(0, 1, 32'h8000, "R4");
        flush();
        send_word(4'd2, 4'd1, 16'h0000);
        expect_item(0, 1, 32'h2222, "R7");
        flush();
        send_word(4'd3, 4'd7, 16'h7777);
        expect_item(0, 7, 32'h7777, "R7");
        expect_item(0, 1, 32'h2222, "R2");
        flush();

        // R13: address 9 aliases channel 1 if truncated; nothing may change
        send_word(4'd3, 4'd9, 16'h9999);
        expect_item(0, 1, 32'h2222, "R13");
        expect_item(0, 7, 32'h7777, "R13");
        flush();

        // R10: power-down mask and gain
        send_word(4'd4, 4'd0, 16'h00A5);
        send_word(4'd5, 4'd0, 16'h0001);
        expect_item(1, 0, 32'hA5, "R10");
        expect_item(2, 0, 32'h1, "R10");
        flush();

        // R11: readback of channel 7 during the following frame
        send_word(4'd6, 4'd7, 16'h0000);
        send_word(4'd0, 4'd0, 16'h0000);
        expect_item(3, 0, 32'h077777, "R11");
        flush();

        // R6: strobe held low, write goes straight through
        ldac_n = 1'b0;
        clks(2);
        send_word(4'd1, 4'd3, 16'h3333);
        expect_item(0, 3, 32'h3333, "R6");
        flush();
        ldac_n = 1'b1;
        clks(2);

        // R8: clear to zero scale, pending data is discarded
        send_word(4'd1, 4'd4, 16'h4444);
        rst_sel = 1'b0;
        clr_n = 1'b0;
        clks(3);
        expect_item(0, 2, 32'h0, "R8");
        expect_item(0, 4, 32'h0, "R8");
        expect_item(0, 7, 32'h0, "R8");
        flush();

        // R9: strobe ignored while clear is low
        send_word(4'd1, 4'd0, 16'h0F0F);
        pulse_ldac();
        expect_item(0, 0, 32'h0, "R9");
        flush();
        clr_n = 1'b1;
        clks(2);
        pulse_ldac();
        expect_item(0, 0, 32'h0F0F, "R9");
        expect_item(0, 4, 32'h0, "R8");
        flush();

        // R12: chaining, 48-bit frame, last 24 bits take effect
        send_word(4'd7, 4'd0, 16'h0001);
        send_bits({24'hABCDEF, 4'd3, 4'd5, 16'h5555}, 48);
        expect_item(3, 0, 32'hABCDEF, "R12");
        expect_item(0, 5, 32'h5555, "R12");
        flush();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule